// File: doc/BRIEF.md
# Memory protection range checker

This block screens each bus transfer against a few programmable address windows and answers allow or deny one clock later. A transfer presents an address, a 4-bit privilege ID, a secure flag, a debug flag and an access type. Each window holds an inclusive start and end address, a 16-bit mask that picks which privilege IDs the window applies to, and attribute bits for secure-only gating, debug enable and read, write and execute permission.

A mask bit that is clear means the window does not apply to that master, so it cannot deny that master's transfers. It does not block the master. To deny a transfer, the window must match the address, the transfer's mask bit must be set, and either a security or debug rule or a permission bit must refuse it. The first denied transfer is recorded in a sticky fault record. A write-one-to-clear operation releases the record.

Software programs the windows through a small word-addressed register port. Reads through the same port are combinational.

Top module: `mprot_chk`

## Requirements
- R1: For every cycle with `xfer_vld` high, `rsp_vld` is high exactly one clock later. `rsp_deny` can be high only while `rsp_vld` is high.
- R2: A window matches when start <= address <= end, both bounds included. A window whose end is below its start matches nothing, and a window never acts on an address outside its bounds.
- R3: A window whose mask bit for the transfer's privilege ID is 0 is skipped and cannot deny that transfer.
- R4: When a window's non-secure attribute (attribute bit 16) is 1, transfers at any security or debug level pass its security check.
- R5: When the non-secure attribute is 0, the window is secure-only. Any transfer with `xfer_sec` = 0 that it checks is denied.
- R6: In a secure-only window, a secure debug transfer is allowed when the debug-enable attribute (bit 17) is 1 and denied when it is 0.
- R7: The access type is encoded as 00 read, 01 write, 10 execute, and 11 is treated as execute. The permission bits are bit 18 (read), bit 19 (write) and bit 20 (execute). A checked window whose bit for the access type is 0 denies the transfer.
- R8: With several windows, a transfer is denied if any matching, checked window denies it. A transfer that no checked window matches is allowed.
- R9: After reset every register reads zero and every transfer is allowed. A window that is all zero never denies.
- R10: Register map, by word address:
  - Window i uses 4i for the start address, 4i+1 for the end address and 4i+2 for the attributes (bits [15:0] mask, 16 non-secure, 17 debug enable, 18 read, 19 write, 20 execute).
  - Address 4i+3 reads zero.
  - Writes take effect at the next clock, and reads return the stored values.
- R11: The first denial sets the fault record:
  - Address 4N holds the status: bit 0 valid, bits [2:1] access type, bits [6:3] privilege ID.
  - Address 4N+1 holds the faulting address.
  - Later denials leave the record unchanged while it is valid.
- R12: A write to address 4N with data bit 0 set clears the whole record to zero. The same write with bit 0 clear has no effect. If a clearing write and a denied transfer fall in the same cycle, the record holds the new fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_vld | input | 1 | Transfer present this cycle |
| xfer_addr | input | AW | Transfer address |
| xfer_pid | input | 4 | Privilege ID |
| xfer_sec | input | 1 | 1 = secure transfer |
| xfer_dbg | input | 1 | 1 = debug transfer |
| xfer_kind | input | 2 | Access type: 00 read, 01 write, 1x execute |
| rsp_vld | output | 1 | Result valid, one cycle after the transfer |
| rsp_deny | output | 1 | 1 = transfer denied |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RAW | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |

## Verification
The checker watches several properties on every cycle:
- Response timing and the qualification of `rsp_deny` by `rsp_vld`.
- No denial unless some window applied the mask bit of the transfer's ID.
- The fault record starts only on a denied response, holds steady until cleared, and drops after a clearing write that meets no new fault.

The truth of each decision can only be shown by the bench's scenarios, which compare against a model. These cover the inclusive bounds, the secure-only and debug gating, the per-type permissions, overlapping windows, register readback and the fault capture after a same-cycle clear.

// File: rtl/mprot_pkg.sv
package mprot_pkg;
  localparam int PID_W = 4;
  localparam int NPID  = 1 << PID_W;

  typedef struct packed {
    logic            ex_ok;
    logic            wr_ok;
    logic            rd_ok;
    logic            dbg_en;
    logic            nonsec;
    logic [NPID-1:0] pid_mask;
  } rng_attr_t;

  localparam int ATTR_W = $bits(rng_attr_t);

  localparam logic [1:0] KIND_RD = 2'b00;
  localparam logic [1:0] KIND_WR = 2'b01;
endpackage

// File: rtl/mprot_range.sv
module mprot_range
  import mprot_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]    lo_addr,
  input  logic [AW-1:0]    hi_addr,
  input  rng_attr_t        attr,
  input  logic [AW-1:0]    addr,
  input  logic [PID_W-1:0] pid,
  input  logic             sec,
  input  logic             dbg,
  input  logic [1:0]       kind,
  output logic             chk,
  output logic             deny
);
  logic in_win, sec_ok, perm_ok;

  always_comb begin
    in_win = (addr >= lo_addr) && (addr <= hi_addr);
    chk    = in_win && attr.pid_mask[pid];
    sec_ok = attr.nonsec || (sec && (!dbg || attr.dbg_en));
    case (kind)
      KIND_RD: perm_ok = attr.rd_ok;
      KIND_WR: perm_ok = attr.wr_ok;
      default: perm_ok = attr.ex_ok;
    endcase
    deny = chk && !(sec_ok && perm_ok);
  end
endmodule

// File: rtl/mprot_regs.sv
module mprot_regs
  import mprot_pkg::*;
#(
  parameter int AW     = 32,
  parameter int NRANGE = 4,
  parameter int RAW    = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [RAW-1:0]  reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [AW-1:0]   lo_q   [NRANGE],
  output logic [AW-1:0]   hi_q   [NRANGE],
  output rng_attr_t       attr_q [NRANGE]
);
  for (genvar i = 0; i < NRANGE; i++) begin : g_win
    logic en_lo, en_hi, en_attr;
    logic [AW-1:0] lo_d, hi_d;
    rng_attr_t attr_d;

    always_comb begin
      en_lo   = reg_we && (reg_addr == RAW'(4*i));
      en_hi   = reg_we && (reg_addr == RAW'(4*i + 1));
      en_attr = reg_we && (reg_addr == RAW'(4*i + 2));
      lo_d    = en_lo   ? reg_wdata[AW-1:0]     : lo_q[i];
      hi_d    = en_hi   ? reg_wdata[AW-1:0]     : hi_q[i];
      attr_d  = en_attr ? reg_wdata[ATTR_W-1:0] : attr_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[i]   <= '0;
        hi_q[i]   <= '0;
        attr_q[i] <= '0;
      end else begin
        lo_q[i]   <= lo_d;
        hi_q[i]   <= hi_d;
        attr_q[i] <= attr_d;
      end
    end
  end
endmodule

// File: rtl/mprot_fault.sv
module mprot_fault
  import mprot_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             clr,
  input  logic [AW-1:0]    addr,
  input  logic [PID_W-1:0] pid,
  input  logic [1:0]       kind,
  output logic             flt_vld,
  output logic [AW-1:0]    flt_addr,
  output logic [PID_W-1:0] flt_pid,
  output logic [1:0]       flt_kind
);
  logic             vld_d;
  logic [AW-1:0]    addr_d;
  logic [PID_W-1:0] pid_d;
  logic [1:0]       kind_d;
  logic             load;

  always_comb begin
    load   = capture && (!flt_vld || clr);
    vld_d  = flt_vld;
    addr_d = flt_addr;
    pid_d  = flt_pid;
    kind_d = flt_kind;
    if (load) begin
      vld_d  = 1'b1;
      addr_d = addr;
      pid_d  = pid;
      kind_d = kind;
    end else if (clr) begin
      vld_d  = 1'b0;
      addr_d = '0;
      pid_d  = '0;
      kind_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_vld  <= 1'b0;
      flt_addr <= '0;
      flt_pid  <= '0;
      flt_kind <= '0;
    end else begin
      flt_vld  <= vld_d;
      flt_addr <= addr_d;
      flt_pid  <= pid_d;
      flt_kind <= kind_d;
    end
  end
endmodule

// File: rtl/mprot_chk.sv
module mprot_chk
  import mprot_pkg::*;
#(
  parameter int AW     = 32,
  parameter int NRANGE = 4,
  parameter int RAW    = $clog2(4*NRANGE + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_vld,
  input  logic [AW-1:0]    xfer_addr,
  input  logic [PID_W-1:0] xfer_pid,
  input  logic             xfer_sec,
  input  logic             xfer_dbg,
  input  logic [1:0]       xfer_kind,
  output logic             rsp_vld,
  output logic             rsp_deny,
  input  logic             reg_we,
  input  logic [RAW-1:0]   reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata
);
  localparam logic [RAW-1:0] FLT_ST = RAW'(4*NRANGE);
  localparam logic [RAW-1:0] FLT_AD = RAW'(4*NRANGE + 1);

  logic [AW-1:0]    lo_q   [NRANGE];
  logic [AW-1:0]    hi_q   [NRANGE];
  rng_attr_t        attr_q [NRANGE];
  logic [NRANGE-1:0] rng_chk, rng_deny;
  logic             any_deny, flt_clr;
  logic             flt_vld;
  logic [AW-1:0]    flt_addr;
  logic [PID_W-1:0] flt_pid;
  logic [1:0]       flt_kind;
  logic             rsp_vld_d, rsp_deny_d;

  mprot_regs #(.AW(AW), .NRANGE(NRANGE), .RAW(RAW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .lo_q(lo_q), .hi_q(hi_q), .attr_q(attr_q)
  );

  for (genvar i = 0; i < NRANGE; i++) begin : g_rng
    mprot_range #(.AW(AW)) u_rng (
      .lo_addr(lo_q[i]), .hi_addr(hi_q[i]), .attr(attr_q[i]),
      .addr(xfer_addr), .pid(xfer_pid), .sec(xfer_sec), .dbg(xfer_dbg),
      .kind(xfer_kind), .chk(rng_chk[i]), .deny(rng_deny[i])
    );
  end

  always_comb begin
    any_deny   = xfer_vld && (|rng_deny);
    flt_clr    = reg_we && (reg_addr == FLT_ST) && reg_wdata[0];
    rsp_vld_d  = xfer_vld;
    rsp_deny_d = any_deny;
  end

  mprot_fault #(.AW(AW)) u_flt (
    .clk(clk), .rst_n(rst_n), .capture(any_deny), .clr(flt_clr),
    .addr(xfer_addr), .pid(xfer_pid), .kind(xfer_kind),
    .flt_vld(flt_vld), .flt_addr(flt_addr), .flt_pid(flt_pid),
    .flt_kind(flt_kind)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld  <= 1'b0;
      rsp_deny <= 1'b0;
    end else begin
      rsp_vld  <= rsp_vld_d;
      rsp_deny <= rsp_deny_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NRANGE; i++) begin
      if (reg_addr == RAW'(4*i))     reg_rdata[AW-1:0]     = lo_q[i];
      if (reg_addr == RAW'(4*i + 1)) reg_rdata[AW-1:0]     = hi_q[i];
      if (reg_addr == RAW'(4*i + 2)) reg_rdata[ATTR_W-1:0] = attr_q[i];
    end
    if (reg_addr == FLT_ST) reg_rdata[PID_W+2:0] = {flt_pid, flt_kind, flt_vld};
    if (reg_addr == FLT_AD) reg_rdata[AW-1:0]    = flt_addr;
  end
endmodule

// File: rtl/mprot_chk_sva.sv
module mprot_chk_sva #(
  parameter int AW     = 32,
  parameter int NRANGE = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xfer_vld,
  input logic              rsp_vld,
  input logic              rsp_deny,
  input logic [NRANGE-1:0] rng_chk,
  input logic [NRANGE-1:0] rng_deny,
  input logic              flt_clr,
  input logic              flt_vld,
  input logic [AW-1:0]     flt_addr
);
  p_rsp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_vld |=> rsp_vld);
  p_rsp_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_vld |=> !rsp_vld);
  p_deny_qual_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_deny |-> rsp_vld);
  p_deny_needs_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_deny |-> $past(|rng_chk));
  p_fault_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_vld) |-> rsp_deny);
  p_fault_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_vld && !flt_clr) |=> (flt_vld && $stable(flt_addr)));
  p_fault_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_clr && !(xfer_vld && |rng_deny)) |=> !flt_vld);
endmodule

bind mprot_chk mprot_chk_sva #(.AW(AW), .NRANGE(NRANGE)) u_sva (
  .clk(clk), .rst_n(rst_n), .xfer_vld(xfer_vld), .rsp_vld(rsp_vld),
  .rsp_deny(rsp_deny), .rng_chk(rng_chk), .rng_deny(rng_deny),
  .flt_clr(flt_clr), .flt_vld(flt_vld), .flt_addr(flt_addr)
);

// File: tb/sim_mprot_chk.sv
`timescale 1ns/1ps
module sim_mprot_chk;
  localparam int AW = 32;
  localparam int NR = 4;
  localparam int RAW = 5;
  localparam logic [RAW-1:0] A_ST = 5'd16;
  localparam logic [RAW-1:0] A_FA = 5'd17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xfer_vld = 0, xfer_sec = 0, xfer_dbg = 0;
  logic [AW-1:0] xfer_addr = '0;
  logic [3:0] xfer_pid = '0;
  logic [1:0] xfer_kind = '0;
  logic rsp_vld, rsp_deny;
  logic reg_we = 0;
  logic [RAW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;

  always #4 clk = ~clk;

  mprot_chk u0 (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [31:0] m_lo [NR], m_hi [NR];
  logic [20:0] m_at [NR];
  logic m_fv; logic [31:0] m_fa; logic [3:0] m_fp; logic [1:0] m_fk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic model_deny(logic [31:0] a, logic [3:0] p,
                                      logic s, logic d, logic [1:0] k);
    logic dn = 0;
    for (int i = 0; i < NR; i++) begin
      logic hit, secok, perm;
      hit   = (a >= m_lo[i]) && (a <= m_hi[i]) && m_at[i][p];
      secok = m_at[i][16] || (s && (!d || m_at[i][17]));
      perm  = (k == 2'b00) ? m_at[i][18] : (k == 2'b01) ? m_at[i][19] : m_at[i][20];
      if (hit && !(secok && perm)) dn = 1;
    end
    return dn;
  endfunction

  task automatic mclear();
    m_fv = 0; m_fa = '0; m_fp = '0; m_fk = '0;
  endtask

  task automatic wr(logic [RAW-1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    if (a < 16) begin
      case (a[1:0])
        2'd0: m_lo[a[4:2]] = d;
        2'd1: m_hi[a[4:2]] = d;
        2'd2: m_at[a[4:2]] = d[20:0];
        default: ;
      endcase
    end else if (a == A_ST && d[0]) mclear();
  endtask

  task automatic rd(string req, logic [RAW-1:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic xf(string req, logic [31:0] a, logic [3:0] p, logic s,
                    logic d, logic [1:0] k);
    logic e;
    @(negedge clk);
    xfer_vld = 1; xfer_addr = a; xfer_pid = p; xfer_sec = s; xfer_dbg = d; xfer_kind = k;
    e = model_deny(a, p, s, d, k);
    @(negedge clk);
    xfer_vld = 0;
    check({req, " rsp_vld"}, 32'(rsp_vld), 32'd1);
    check({req, " rsp_deny"}, 32'(rsp_deny), 32'(e));
    if (e && !m_fv) begin m_fv = 1; m_fa = a; m_fp = p; m_fk = k; end
  endtask

  task automatic chk_fault(string req);
    rd(req, A_ST, {25'd0, m_fp, m_fk, m_fv});
    rd(req, A_FA, m_fa);
  endtask

  // attribute word: mask | nonsec<<16 | dbg<<17 | rd<<18 | wr<<19 | ex<<20
  function automatic logic [31:0] at(logic [15:0] m, logic ns, logic de,
                                     logic r, logic w, logic x);
    return {11'd0, x, w, r, de, ns, m};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < NR; i++) begin m_lo[i] = 0; m_hi[i] = 0; m_at[i] = 0; end
    mclear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    check("R9 rsp_vld reset", 32'(rsp_vld), 32'd0);
    rd("R9 attr0 reset", 5'd2, 32'd0);
    rd("R9 hi3 reset", 5'd13, 32'd0);
    chk_fault("R9 fault reset");
    xf("R9 all-zero allows", 32'h0, 4'd0, 0, 1, 2'b01);
    xf("R9 all-zero allows", 32'hFFFF_FFFF, 4'd15, 0, 0, 2'b10);
    @(negedge clk);
    check("R1 idle no rsp", 32'(rsp_vld), 32'd0);

    // R2/R10: window 0 = [0x100,0x1FF], pid 3, no permissions
    wr(5'd0, 32'h100); wr(5'd1, 32'h1FF); wr(5'd2, at(16'h0008, 1, 0, 0, 0, 0));
    rd("R10 lo0", 5'd0, 32'h100);
    rd("R10 hi0", 5'd1, 32'h1FF);
    rd("R10 attr0", 5'd2, at(16'h0008, 1, 0, 0, 0, 0));
    rd("R10 gap reads zero", 5'd3, 32'd0);
    xf("R2 low bound", 32'h100, 4'd3, 1, 0, 2'b00);
    chk_fault("R11 first fault");
    xf("R2 high bound", 32'h1FF, 4'd3, 1, 0, 2'b00);
    xf("R2 below", 32'hFF, 4'd3, 1, 0, 2'b00);
    xf("R2 above", 32'h200, 4'd3, 1, 0, 2'b00);
    xf("R3 unmasked pid", 32'h150, 4'd4, 0, 1, 2'b01);
    chk_fault("R11 sticky");

    // R7 permissions
    wr(5'd2, at(16'h0008, 1, 0, 1, 0, 0));
    xf("R7 read ok", 32'h150, 4'd3, 1, 0, 2'b00);
    xf("R7 write deny", 32'h150, 4'd3, 1, 0, 2'b01);
    xf("R7 exec deny", 32'h150, 4'd3, 1, 0, 2'b10);
    wr(5'd2, at(16'h0008, 1, 0, 0, 1, 1));
    xf("R7 kind3 as exec", 32'h150, 4'd3, 1, 0, 2'b11);
    xf("R7 read deny", 32'h150, 4'd3, 1, 0, 2'b00);

    // R4/R5/R6 security and debug gating
    wr(5'd2, at(16'h0008, 0, 0, 1, 1, 1));
    xf("R5 nonsec denied", 32'h150, 4'd3, 0, 0, 2'b00);
    xf("R5 secure ok", 32'h150, 4'd3, 1, 0, 2'b00);
    xf("R6 sec dbg denied", 32'h150, 4'd3, 1, 1, 2'b00);
    wr(5'd2, at(16'h0008, 0, 1, 1, 1, 1));
    xf("R6 sec dbg allowed", 32'h150, 4'd3, 1, 1, 2'b00);
    xf("R5 nonsec dbg denied", 32'h150, 4'd3, 0, 1, 2'b00);
    wr(5'd2, at(16'h0008, 1, 0, 1, 1, 1));
    xf("R4 nonsec dbg ok", 32'h150, 4'd3, 0, 1, 2'b10);

    // R8 overlapping windows: window 1 allows, window 0 denies writes
    wr(5'd4, 32'h0); wr(5'd5, 32'hFFF); wr(5'd6, at(16'hFFFF, 1, 1, 1, 1, 1));
    wr(5'd2, at(16'h0008, 1, 0, 1, 0, 1));
    xf("R8 any denies", 32'h180, 4'd3, 1, 0, 2'b01);
    xf("R8 all allow", 32'h180, 4'd3, 1, 0, 2'b00);
    // R2 inverted window
    wr(5'd8, 32'h900); wr(5'd9, 32'h800); wr(5'd10, at(16'hFFFF, 0, 0, 0, 0, 0));
    xf("R2 empty window", 32'h850, 4'd1, 0, 0, 2'b00);
    chk_fault("R11 still first");

    // R12 clear behaviour
    wr(A_ST, 32'hFFFF_FFFE);
    chk_fault("R12 bit0 clear no effect");
    wr(A_ST, 32'h1);
    chk_fault("R12 cleared");
    xf("R12 new fault", 32'h1A0, 4'd3, 1, 0, 2'b01);
    chk_fault("R12 recapture");
    // same-cycle clear and denied transfer: new fault kept
    @(negedge clk);
    reg_we = 1; reg_addr = A_ST; reg_wdata = 32'h1;
    xfer_vld = 1; xfer_addr = 32'h1C4; xfer_pid = 4'd3; xfer_sec = 1; xfer_dbg = 0; xfer_kind = 2'b01;
    @(negedge clk);
    reg_we = 0; xfer_vld = 0;
    check("R12 same-cycle deny", 32'(rsp_deny), 32'd1);
    m_fv = 1; m_fa = 32'h1C4; m_fp = 4'd3; m_fk = 2'b01;
    chk_fault("R12 same-cycle capture");

    // random mix
    for (int ep = 0; ep < 40; ep++) begin
      for (int i = 0; i < NR; i++) begin
        logic [31:0] lo;
        lo = $urandom & 32'h3FF;
        wr(RAW'(4*i), lo);
        wr(RAW'(4*i+1), lo + ($urandom & 32'hFF) - 32'h10);
        wr(RAW'(4*i+2), $urandom & 32'h1F_FFFF & ($urandom | 32'h1F_0000));
      end
      for (int t = 0; t < 60; t++) begin
        xf("R8 random", $urandom & 32'h4FF, 4'($urandom), 1'($urandom),
           1'($urandom), 2'($urandom));
        if (($urandom & 31) == 0) wr(A_ST, 32'h1);
      end
      chk_fault("R11 random fault");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule